// File: doc/BRIEF.md
# Byte-wide host scan data port

This block sits between an 8-bit microprocessor-style bus and a bit-serial scan engine. The host writes outgoing scan bytes into a four-entry transmit queue. Each byte is shifted out one bit at a time, least significant bit first, as the engine asks for bits. Bits returning from the scan chain are packed into bytes and placed in a four-entry receive queue for the host to read. A mode field can feed the receive side from the transmitted bit or from the engine's mode-select bit instead of the chain input, so the host can check what was driven.

The host strobe is asynchronous to the block clock and passes through a two-flop synchronizer. The ready output rises only after the access has taken effect. When a write meets a full transmit queue, or a read meets an empty receive queue, ready stays low until the request can be served. The host sees this as wait states and does not need to poll.

The scan engine is modelled by a per-bit strobe. The strobe carries a flag that marks the final bit of a scan, and the last byte of a scan may be partial.

Top module: `hscan_host_if`

## Requirements
- R1: After reset, `host_ready` and `tx_valid` are low, both queue counts are zero and the mode field is 00.
- R2: `host_ready` rises in the third clock after `host_strobe` rises, once the access has been committed, and each strobe commits exactly one access. After the strobe falls, `host_ready` falls in the third clock.
- R3: A write to address 0 appends the data byte to the transmit queue. `tx_bit` presents the head byte least significant bit first and advances one bit per `bit_stb`. The byte leaves the queue after its eighth bit.
- R4: On each `bit_stb` the captured bit is placed at the next bit position, counting from bit 0. After eight bits the byte enters the receive queue, and reads from address 1 return bytes in arrival order.
- R5: A `bit_stb` with `bit_last` high ends the byte. A partial receive byte is queued right-justified with its unused upper bits zero, and a partly sent transmit byte is dropped.
- R6: The mode field is written and read through address 2, bits [1:0]. 01 captures `tx_bit`, 10 captures `tms_in`, and 00 or 11 captures `tdi_in`. The field changes only on a committed write.
- R7: A write to address 0 with the transmit queue full, or a read from address 1 with the receive queue empty, holds `host_ready` low until room or data appears. The access then completes.
- R8: A read from address 3 returns status: bit 7 `seq_err`, bit 6 `seq_busy`, bits [5:3] the receive count and bits [2:0] the transmit count.
- R9: Writes to addresses 1 and 3 to 7 have no effect. Reads from address 0 and from addresses 4 to 7 return zero.
- R10: Neither queue count ever exceeds the queue depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| host_strobe | input | 1 | Asynchronous access strobe |
| host_rw | input | 1 | 1 selects read, 0 selects write |
| host_addr | input | 3 | Register address |
| host_din | input | 8 | Write data from host |
| host_dout | output | 8 | Read data, held after the access |
| host_ready | output | 1 | Access done; low inserts wait states |
| bit_stb | input | 1 | One scan bit shifted and captured |
| bit_last | input | 1 | Marks the final bit of a scan |
| tdi_in | input | 1 | Bit returning from the scan chain |
| tms_in | input | 1 | Current mode-select bit driven by the engine |
| tx_valid | output | 1 | Transmit queue holds a bit |
| tx_bit | output | 1 | Current outgoing bit |
| seq_busy | input | 1 | Engine busy flag for status |
| seq_err | input | 1 | Engine error flag for status |

## Verification
The assertions assume the engine strobes a bit only when `tx_valid` is high and the receive queue has room. They also assume the host holds address, direction and data steady from the strobe's rise until ready rises. The bench drives each serial bit only after confirming `tx_valid` against its model, and it drains the receive queue before it can fill. Host signals are set one half cycle before the strobe and are released only after ready has been observed.

// File: rtl/hscan_host_if.sv
module hscan_host_if #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_strobe,
  input  logic         host_rw,
  input  logic [2:0]   host_addr,
  input  logic [W-1:0] host_din,
  output logic [W-1:0] host_dout,
  output logic         host_ready,
  input  logic         bit_stb,
  input  logic         bit_last,
  input  logic         tdi_in,
  input  logic         tms_in,
  output logic         tx_valid,
  output logic         tx_bit,
  input  logic         seq_busy,
  input  logic         seq_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(W);

  logic          s1, s2, done;
  logic [1:0]    mode;
  logic [W-1:0]  tx_mem [DEPTH];
  logic [W-1:0]  rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [BW-1:0] bcnt;
  logic [W-1:0]  acc, acc_n;
  logic          pend, wr_go, rd_go, oth_go, commit;
  logic          tx_pop, rx_push, cap, byte_end;
  logic [W-1:0]  rd_val;

  assign pend   = s2 & ~done;
  assign wr_go  = pend & ~host_rw & (host_addr == 3'd0) & (tx_cnt != CW'(DEPTH));
  assign rd_go  = pend &  host_rw & (host_addr == 3'd1) & (rx_cnt != '0);
  assign oth_go = pend & ~((host_addr == 3'd0) & ~host_rw) & ~((host_addr == 3'd1) & host_rw);
  assign commit = wr_go | rd_go | oth_go;

  assign tx_valid = (tx_cnt != '0);
  assign tx_bit   = tx_valid ? tx_mem[tx_rp][bcnt] : 1'b0;
  assign byte_end = bit_stb & ((bcnt == BW'(W - 1)) | bit_last);
  assign tx_pop   = byte_end & tx_valid;
  assign rx_push  = byte_end;
  assign cap      = (mode == 2'b01) ? tx_bit : (mode == 2'b10) ? tms_in : tdi_in;
  assign acc_n    = acc | (W'(cap) << bcnt);

  always_comb begin
    case (host_addr)
      3'd1:    rd_val = rx_mem[rx_rp];
      3'd2:    rd_val = W'(mode);
      3'd3:    rd_val = W'({seq_err, seq_busy, rx_cnt, tx_cnt});
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; done <= 1'b0;
      mode <= 2'b00; host_dout <= '0;
    end else begin
      s1 <= host_strobe;
      s2 <= s1;
      if (commit) done <= 1'b1;
      else if (!s2) done <= 1'b0;
      if (commit && host_rw) host_dout <= rd_val;
      if (oth_go && !host_rw && host_addr == 3'd2) mode <= host_din[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) tx_mem[tx_wp] <= host_din;
    if (rx_push) rx_mem[rx_wp] <= acc_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      bcnt <= '0; acc <= '0;
    end else begin
      if (wr_go)  tx_wp <= tx_wp + 1'b1;
      if (tx_pop) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(wr_go) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rd_go)   rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rd_go);
      if (byte_end) begin
        bcnt <= '0; acc <= '0;
      end else if (bit_stb) begin
        bcnt <= bcnt + 1'b1; acc <= acc_n;
      end
    end
  end

  assign host_ready = done;

  p_tx_bound_r10: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH));
  p_rx_bound_r10: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= CW'(DEPTH));
  p_legal_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (tx_cnt != '0) && (rx_cnt != CW'(DEPTH)));
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && !s2) |=> !host_ready);
  p_wait_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !host_rw && host_addr == 3'd0 && tx_cnt == CW'(DEPTH)) |=> !host_ready);
  p_wait_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && host_rw && host_addr == 3'd1 && rx_cnt == '0) |=> !host_ready);
  p_bit_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && bit_last) |=> (bcnt == '0));
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && !host_rw && host_addr == 3'd2) |=> $stable(mode));
endmodule

// File: tb/hscan_host_if_bench.sv
module hscan_host_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_strobe = 1'b0, host_rw = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_din = '0, host_dout;
  logic host_ready, tx_valid, tx_bit;
  logic bit_stb = 1'b0, bit_last = 1'b0, tdi_in = 1'b0, tms_in = 1'b0;
  logic seq_busy = 1'b0, seq_err = 1'b0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  hscan_host_if u_hscan_host_if (.*);

  byte unsigned txq[$];
  byte unsigned rxq[$];
  int bpos = 0;
  byte unsigned acc = 0;
  int mode_m = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit rw, input logic [2:0] a, input byte unsigned d,
                        output byte unsigned q, output int up_n, output int dn_n);
    @(negedge clk);
    host_rw = rw; host_addr = a; host_din = d; host_strobe = 1'b1;
    up_n = 0;
    do begin @(negedge clk); up_n++; end while (!host_ready);
    q = host_dout;
    host_strobe = 1'b0;
    dn_n = 0;
    do begin @(negedge clk); dn_n++; end while (host_ready);
    if (!rw && a == 3'd0) txq.push_back(d);
    if (!rw && a == 3'd2) mode_m = d & 3;
  endtask

  task automatic wr(input logic [2:0] a, input byte unsigned d);
    byte unsigned q; int u, n;
    access(1'b0, a, d, q, u, n);
  endtask

  task automatic rd(input logic [2:0] a, output byte unsigned q);
    int u, n;
    access(1'b1, a, 8'h00, q, u, n);
  endtask

  task automatic sbit(input bit last, input bit din, input bit tms);
    bit eo, c;
    @(negedge clk);
    chk(tx_valid == (txq.size() != 0), "R3 tx_valid", tx_valid, txq.size() != 0);
    eo = (txq.size() != 0) ? txq[0][bpos] : 1'b0;
    chk(tx_bit == eo, "R3 tx_bit", tx_bit, eo);
    c = (mode_m == 1) ? eo : (mode_m == 2) ? tms : din;
    acc = acc | (byte'(c) << bpos);
    bit_stb = 1'b1; bit_last = last; tdi_in = din; tms_in = tms;
    if (bpos == 7 || last) begin
      rxq.push_back(acc); acc = 0; bpos = 0;
      if (txq.size() != 0) void'(txq.pop_front());
    end else bpos++;
    @(negedge clk);
    bit_stb = 1'b0; bit_last = 1'b0;
  endtask

  task automatic sbyte(input byte unsigned din, input byte unsigned tms, input int nbits);
    for (int i = 0; i < nbits; i++) sbit(i == nbits - 1 && nbits < 8, din[i], tms[i]);
  endtask

  task automatic rx_read(input string req);
    byte unsigned q, e;
    e = rxq.pop_front();
    rd(3'd1, q);
    chk(q == e, req, q, e);
  endtask

  task automatic stat(input string req);
    byte unsigned q, e;
    rd(3'd3, q);
    e = {seq_err, seq_busy, 3'(rxq.size()), 3'(txq.size())};
    chk(q == e, req, q, e);
  endtask

  task automatic run_all;
    byte unsigned q; int u, n;
    chk(host_ready == 1'b0, "R1 ready", host_ready, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    rst_n = 1'b1;
    stat("R1 status");
    rd(3'd2, q); chk(q == 8'h00, "R1 mode", q, 0);
    access(1'b0, 3'd0, 8'hA5, q, u, n);
    chk(u == 3, "R2 ready rise", u, 3);
    chk(n == 3, "R2 ready fall", n, 3);
    wr(3'd0, 8'h3C);
    stat("R3 count after writes");
    sbyte(8'h96, 8'h00, 8);
    sbyte(8'h0F, 8'h00, 8);
    stat("R4 counts after shift");
    rx_read("R4 first byte");
    rx_read("R4 second byte");
    wr(3'd0, 8'hFF);
    sbyte(8'h05, 8'h00, 3);
    stat("R5 partial byte dropped");
    rx_read("R5 right-justified");
    wr(3'd2, 8'h01); rd(3'd2, q); chk(q == 8'h01, "R6 mode read", q, 1);
    wr(3'd0, 8'hC3); sbyte(8'h00, 8'h00, 8); rx_read("R6 tx loopback");
    wr(3'd2, 8'h02); wr(3'd0, 8'h00); sbyte(8'hFF, 8'h5A, 8); rx_read("R6 tms loopback");
    wr(3'd2, 8'h03); wr(3'd0, 8'h00); sbyte(8'h6B, 8'hFF, 8); rx_read("R6 mode 11 external");
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h11);
    fork
      begin
        byte unsigned e;
        rd(3'd1, q);
        e = rxq.pop_front();
        chk(q == e, "R7 stalled read data", q, e);
      end
      begin
        repeat (10) @(negedge clk);
        chk(host_ready == 1'b0, "R7 empty read waits", host_ready, 0);
        sbyte(8'h77, 8'h00, 8);
      end
    join
    for (int i = 0; i < 4; i++) wr(3'd0, 8'(8'h20 + i));
    fork
      wr(3'd0, 8'h99);
      begin
        repeat (10) @(negedge clk);
        chk(host_ready == 1'b0, "R7 full write waits", host_ready, 0);
        sbyte(8'h01, 8'h00, 8);
      end
    join
    stat("R7 counts after stall");
    rx_read("R7 drained byte");
    for (int i = 0; i < 4; i++) begin
      sbyte(8'(i * 37), 8'h00, 8);
      rx_read("R3 queue order");
    end
    seq_busy = 1'b1; seq_err = 1'b1;
    stat("R8 flags");
    seq_busy = 1'b0;
    stat("R8 error only");
    seq_err = 1'b0;
    for (int a = 4; a < 8; a++) begin
      wr(3'(a), 8'hFF);
      rd(3'(a), q); chk(q == 8'h00, "R9 unused read", q, 0);
    end
    wr(3'd3, 8'hFF); wr(3'd1, 8'hFF);
    stat("R9 ignored writes");
    rd(3'd2, q); chk(q == 8'h00, "R9 mode untouched", q, 0);
    rd(3'd0, q); chk(q == 8'h00, "R9 data port reads zero", q, 0);
    chk(tx_valid == 1'b0, "R10 queues empty", tx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule